// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words (1 sign bit, an 8-bit exponent biased by 127, a 23-bit fraction) and returns a packed result of the same format. It splits each operand into its fields and puts back the implicit leading one. It then swaps the operands so that the one with the larger magnitude comes first. The other operand is shifted right by the exponent difference, and three extra low bits keep what falls off the end. The block adds or subtracts the significands, renormalizes, rounds to nearest with ties to even, and repacks the fields.

Subnormal operands count as zero. A result whose exponent would reach the all-ones code becomes a signed infinity and raises an overflow flag. A nonzero result whose exponent would reach zero or below becomes a signed zero and raises an underflow flag. The datapath is combinational up to a single output register. A valid/ready pair on each side lets a producer and a consumer apply backpressure, and the block can accept a new operation every cycle while the output is being taken.

Top module: `fpadd_top`

## Requirements
- R1: Words are laid out as sign in bit 31, exponent in bits 30..23 (bias 127) and fraction in bits 22..0. 0x3F000000 plus 0xBEE00000 gives 0x3D800000 (exponent field 123, fraction 0). 0xC0A00000 plus 0xBF400000 gives 0xC0B80000.
- R2: An operand with exponent field 0 is zero, whatever its fraction. x plus such a zero returns x unchanged. -0 plus -0 gives 0x80000000. +0 plus -0 gives 0x00000000.
- R3: When nonzero operands of unlike effective sign cancel exactly, the result is +0 (0x00000000).
- R4: For normal operands, the result equals the exact sum rounded to the nearest value with a 24-bit significand, with ties going to the even significand.
- R5: When like effective signs give a significand of 2 or more, the result is shifted right once and the exponent rises by one (1.5 + 1.5 = 0x40400000).
- R6: When unlike signs leave leading zeros, the result is shifted left until normalized and the exponent drops by the shift count (0x3F800001 - 0x3F800000 = 0x34000000).
- R7: When rounding carries out of the significand, the result is renormalized (0x3F7FFFFF + 0x33000000 = 0x3F800000).
- R8: A result exponent of 255 or more gives exponent field 255 with fraction 0 and the result's sign, and sets out_ovf.
- R9: A nonzero result whose exponent is 0 or below gives a signed zero and sets out_unf (0x00800000 + 0x80C00000 = 0x80000000).
- R10: With in_sub high, the sign of in_b is inverted before the operation.
- R11: in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid stays high and out_sum stays unchanged. Results leave in the order in which operations were accepted, one result for each accepted operation.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_sub | input | 1 | 1: compute a - b; 0: compute a + b |
| out_valid | output | 1 | Result held on out_sum |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 32 | Packed result |
| out_ovf | output | 1 | Result saturated to infinity |
| out_unf | output | 1 | Nonzero result flushed to zero |

## Verification
Every internal fault in the arithmetic reaches the ports in the same cycle that the affected result becomes valid, one edge after the operation is accepted. A misplaced alignment shift or a lost sticky bit shows only as a one-unit error in the last place on specific tie or near-tie inputs, so the sweeps concentrate on close exponents, fractions with many trailing zeros and cancellation. A wrong normalization count shows as an exponent error on cancelling pairs. A broken hold register shows as a changed output during a stall or as a missing or duplicated result in the ordered stream.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
   localparam int unsigned DEF_EXP_W  = 8;
   localparam int unsigned DEF_FRAC_W = 23;
   // guard, round and sticky positions below the significand
   localparam int unsigned GRS_W = 3;

   function automatic int unsigned work_width(input int unsigned frac_w);
      return frac_w + 1 + GRS_W;
   endfunction
endpackage

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
module fpadd_align #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
   localparam int unsigned WRK_W  = fpadd_pkg::work_width(FRAC_W)
) (
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic              op_sub,
   output logic              big_sign,
   output logic              eff_sub,
   output logic [EXP_W-1:0]  big_exp,
   output logic [WRK_W-1:0]  big_sig,
   output logic [WRK_W-1:0]  small_sig
);
   localparam int unsigned MAN_W = FRAC_W + 1;
   localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(WRK_W);

   logic              sgn_a, sgn_b;
   logic [EXP_W-1:0]  exp_a, exp_b, small_exp, diff;
   logic [FRAC_W-1:0] frc_a, frc_b;
   logic [MAN_W-1:0]  man_a, man_b, small_man, big_man;
   logic              a_first, lost;
   logic [WRK_W-1:0]  ext, shifted, lost_mask;

   assign sgn_a = op_a[WORD_W-1];
   assign sgn_b = op_b[WORD_W-1] ^ op_sub;          // R10: subtract flips b
   assign exp_a = op_a[WORD_W-2:FRAC_W];
   assign exp_b = op_b[WORD_W-2:FRAC_W];
   assign frc_a = op_a[FRAC_W-1:0];
   assign frc_b = op_b[FRAC_W-1:0];

   // R2: exponent code 0 (zero or subnormal) flushes the significand
   assign man_a = (exp_a == '0) ? '0 : {1'b1, frc_a};
   assign man_b = (exp_b == '0) ? '0 : {1'b1, frc_b};

   assign a_first   = {exp_a, frc_a} >= {exp_b, frc_b};
   assign big_sign  = a_first ? sgn_a : sgn_b;
   assign big_exp   = a_first ? exp_a : exp_b;
   assign small_exp = a_first ? exp_b : exp_a;
   assign big_man   = a_first ? man_a : man_b;
   assign small_man = a_first ? man_b : man_a;
   assign eff_sub   = sgn_a ^ sgn_b;
   assign diff      = big_exp - small_exp;

   assign big_sig = {big_man, {fpadd_pkg::GRS_W{1'b0}}};
   assign ext     = {small_man, {fpadd_pkg::GRS_W{1'b0}}};

   always_comb begin
      if (diff >= SHIFT_LIM) begin
         shifted   = '0;
         lost_mask = '1;
      end else begin
         shifted   = ext >> diff;
         lost_mask = ~({WRK_W{1'b1}} << diff);
      end
      lost = |(ext & lost_mask);
   end

   // R4: everything shifted out collapses into the sticky position
   assign small_sig = {shifted[WRK_W-1:1], shifted[0] | lost};
endmodule

// File: rtl/fpadd_sum_norm.sv
`timescale 1ns/1ps
module fpadd_sum_norm #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned WRK_W = fpadd_pkg::work_width(FRAC_W),
   localparam int unsigned EXI_W = EXP_W + 2
) (
   input  logic [WRK_W-1:0] big_sig,
   input  logic [WRK_W-1:0] small_sig,
   input  logic             eff_sub,
   input  logic [EXP_W-1:0] big_exp,
   output logic [WRK_W-1:0] norm_sig,
   output logic [EXI_W-1:0] norm_exp,
   output logic             sum_zero
);
   localparam int unsigned LZ_W = $clog2(WRK_W + 1);

   logic [WRK_W:0]  sum;
   logic [LZ_W-1:0] lz;

   function automatic logic [LZ_W-1:0] lead_zeros(input logic [WRK_W-1:0] v);
      logic [LZ_W-1:0] n;
      n = LZ_W'(WRK_W);
      for (int i = 0; i < WRK_W; i++) begin
         if (v[i]) n = LZ_W'(WRK_W - 1 - i);
      end
      return n;
   endfunction

   assign sum = eff_sub ? ({1'b0, big_sig} - {1'b0, small_sig})
                        : ({1'b0, big_sig} + {1'b0, small_sig});
   assign sum_zero = (sum == '0);
   assign lz = lead_zeros(sum[WRK_W-1:0]);

   always_comb begin
      if (sum[WRK_W]) begin
         // R5: carry out, one step right, keep the sticky
         norm_sig = {sum[WRK_W:2], sum[1] | sum[0]};
         norm_exp = EXI_W'(big_exp) + EXI_W'(1);
      end else begin
         // R6: cancellation, shift left by the leading-zero count
         norm_sig = sum[WRK_W-1:0] << lz;
         norm_exp = EXI_W'(big_exp) - EXI_W'(lz);
      end
   end
endmodule

// File: rtl/fpadd_round_pack.sv
`timescale 1ns/1ps
module fpadd_round_pack #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
   localparam int unsigned WRK_W  = fpadd_pkg::work_width(FRAC_W),
   localparam int unsigned EXI_W  = EXP_W + 2
) (
   input  logic [WRK_W-1:0]  norm_sig,
   input  logic [EXI_W-1:0]  norm_exp,
   input  logic              sum_zero,
   input  logic              big_sign,
   input  logic              eff_sub,
   output logic [WORD_W-1:0] res_word,
   output logic              res_ovf,
   output logic              res_unf
);
   localparam int unsigned MAN_W = FRAC_W + 1;
   localparam logic [EXI_W-1:0] EXP_TOP = EXI_W'((1 << EXP_W) - 1);

   logic [MAN_W-1:0] man, man_f;
   logic [MAN_W:0]   man_r;
   logic [EXI_W-1:0] exp_f;
   logic             g_bit, r_bit, s_bit, up, neg;

   assign man   = norm_sig[WRK_W-1:fpadd_pkg::GRS_W];
   assign g_bit = norm_sig[2];
   assign r_bit = norm_sig[1];
   assign s_bit = norm_sig[0];
   // R4: nearest, ties to even
   assign up    = g_bit & (r_bit | s_bit | man[0]);
   assign man_r = {1'b0, man} + (MAN_W + 1)'(up);

   always_comb begin
      if (man_r[MAN_W]) begin
         // R7: rounding carried out, renormalize
         man_f = man_r[MAN_W:1];
         exp_f = norm_exp + EXI_W'(1);
      end else begin
         man_f = man_r[MAN_W-1:0];
         exp_f = norm_exp;
      end
   end

   assign neg = exp_f[EXI_W-1];

   always_comb begin
      res_ovf = 1'b0;
      res_unf = 1'b0;
      if (sum_zero) begin
         res_word = {~eff_sub & big_sign, {(WORD_W-1){1'b0}}};          // R3
      end else if (!neg && exp_f >= EXP_TOP) begin
         res_word = {big_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};           // R8
         res_ovf  = 1'b1;
      end else if (neg || exp_f == '0) begin
         res_word = {big_sign, {(WORD_W-1){1'b0}}};                      // R9
         res_unf  = 1'b1;
      end else begin
         res_word = {big_sign, exp_f[EXP_W-1:0], man_f[FRAC_W-1:0]};    // R1
      end
   end
endmodule

// File: rtl/fpadd_top.sv
`timescale 1ns/1ps
module fpadd_top #(
   parameter int unsigned EXP_W  = fpadd_pkg::DEF_EXP_W,
   parameter int unsigned FRAC_W = fpadd_pkg::DEF_FRAC_W,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_a,
   input  logic [WORD_W-1:0] in_b,
   input  logic              in_sub,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_sum,
   output logic              out_ovf,
   output logic              out_unf
);
   localparam int unsigned WRK_W = fpadd_pkg::work_width(FRAC_W);
   localparam int unsigned EXI_W = EXP_W + 2;

   generate
      if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_width
         $error("fpadd_top: EXP_W must be >= 3 and FRAC_W >= 2");
      end
      if ((1 << EXP_W) <= WRK_W) begin : g_bad_range
         $error("fpadd_top: exponent range too small for the work width");
      end
   endgenerate

   logic              big_sign, eff_sub, sum_zero, res_ovf, res_unf;
   logic [EXP_W-1:0]  big_exp;
   logic [WRK_W-1:0]  big_sig, small_sig, norm_sig;
   logic [EXI_W-1:0]  norm_exp;
   logic [WORD_W-1:0] res_word;

   fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) align_i (
      .op_a(in_a), .op_b(in_b), .op_sub(in_sub),
      .big_sign(big_sign), .eff_sub(eff_sub), .big_exp(big_exp),
      .big_sig(big_sig), .small_sig(small_sig)
   );

   fpadd_sum_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) sum_i (
      .big_sig(big_sig), .small_sig(small_sig), .eff_sub(eff_sub),
      .big_exp(big_exp), .norm_sig(norm_sig), .norm_exp(norm_exp),
      .sum_zero(sum_zero)
   );

   fpadd_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) pack_i (
      .norm_sig(norm_sig), .norm_exp(norm_exp), .sum_zero(sum_zero),
      .big_sign(big_sign), .eff_sub(eff_sub), .res_word(res_word),
      .res_ovf(res_ovf), .res_unf(res_unf)
   );

   // R11: the output register doubles as the only buffer stage
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;                                               // R12
         out_sum   <= '0;
         out_ovf   <= 1'b0;
         out_unf   <= 1'b0;
      end else if (in_valid && in_ready) begin
         out_valid <= 1'b1;
         out_sum   <= res_word;
         out_ovf   <= res_ovf;
         out_unf   <= res_unf;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_sum));

   assert_ovf_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ovf |-> out_sum[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

   assert_unf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_unf |-> out_sum[WORD_W-2:0] == '0 && !out_ovf);

   assert_norm_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !sum_zero |-> norm_sig[WRK_W-1]);

   assert_align_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> small_sig <= big_sig);
endmodule

// File: tb/fpadd_top_tb.sv
`timescale 1ns/1ps
module fpadd_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        in_sub = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_sum;
   logic        out_ovf, out_unf;

   int checks = 0;
   int fails  = 0;
   logic [31:0] seed = 32'h1234_5678;

   // pending operation and its expected {ovf, unf, word}
   logic        have_vec = 1'b0;
   logic [31:0] va, vb;
   logic        vs;
   logic [33:0] vexp;
   string       vtag;
   int          always_ready = 1;

   logic [33:0] q_exp [0:15];
   string       q_tag [0:15];
   int          q_head = 0, q_tail = 0;
   logic        stalled_prev = 1'b0;
   logic [31:0] held_sum;

   always #2.5 clk = ~clk;

   fpadd_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
      .out_ready(out_ready), .out_sum(out_sum), .out_ovf(out_ovf), .out_unf(out_unf)
   );

   function automatic logic [31:0] next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // exact sum, rounded to nearest even, flush and saturate as required
   function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
      logic sa, sb, sr, up;
      int ea, eb, emin, e, p;
      logic [127:0] ma, mb, bg, sm, mag, rem, half;
      logic [24:0] mant;
      sa = a[31]; sb = b[31] ^ sub;
      ea = int'(a[30:23]); eb = int'(b[30:23]);
      ma = (ea == 0) ? 128'd0 : {104'd0, 1'b1, a[22:0]};
      mb = (eb == 0) ? 128'd0 : {104'd0, 1'b1, b[22:0]};
      if (ma == 0 && mb == 0) return {2'b00, sa & sb, 31'd0};
      if (ma == 0) return {2'b00, sb, b[30:0]};
      if (mb == 0) return {2'b00, a};
      if (ea - eb > 60) return {2'b00, a};
      if (eb - ea > 60) return {2'b00, sb, b[30:0]};
      emin = (ea < eb) ? ea : eb;
      ma = ma << (ea - emin);
      mb = mb << (eb - emin);
      if (ma >= mb) begin bg = ma; sm = mb; sr = sa; end
      else          begin bg = mb; sm = ma; sr = sb; end
      mag = (sa == sb) ? bg + sm : bg - sm;
      if (mag == 0) return 34'd0;
      p = 0;
      for (int i = 0; i < 128; i++) if (mag[i]) p = i;
      e = p + emin - 23;
      if (p > 23) begin
         rem  = mag & ((128'd1 << (p - 23)) - 128'd1);
         half = 128'd1 << (p - 24);
         mant = 25'(mag >> (p - 23));
         up   = (rem > half) || (rem == half && mant[0]);
      end else begin
         mant = 25'(mag << (23 - p));
         up   = 1'b0;
      end
      mant = mant + 25'(up);
      if (mant[24]) begin mant = mant >> 1; e = e + 1; end
      if (e >= 255) return {2'b10, sr, 8'hFF, 23'd0};
      if (e <= 0)   return {2'b01, sr, 31'd0};
      return {2'b00, sr, 8'(e), mant[22:0]};
   endfunction

   task automatic check(input string tag, input logic ok, input logic [33:0] act, input logic [33:0] exp_v, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%09h expected=%09h", tag, what, act, exp_v);
      end
   endtask

   // one cycle: drive at the falling edge, observe before the rising edge
   task automatic step();
      logic [31:0] r;
      r = next_rand();
      in_valid  = have_vec;
      in_a      = va;
      in_b      = vb;
      in_sub    = vs;
      out_ready = (always_ready != 0) ? 1'b1 : (r[1:0] != 2'b00);
      #1;
      if (stalled_prev) begin
         // R11: stalled result must stay valid and unchanged
         check("R11", out_valid && out_sum == held_sum, {2'b00, out_sum}, {2'b00, held_sum}, "stall hold");
      end
      if (out_valid && out_ready) begin
         if (q_head == q_tail) begin
            check("R11", 1'b0, {out_ovf, out_unf, out_sum}, 34'd0, "result without operation");
         end else begin
            check(q_tag[q_head % 16], {out_ovf, out_unf, out_sum} == q_exp[q_head % 16],
                  {out_ovf, out_unf, out_sum}, q_exp[q_head % 16], "result");
            q_head++;
         end
      end
      stalled_prev = out_valid && !out_ready;
      held_sum     = out_sum;
      if (in_valid && in_ready) begin
         q_exp[q_tail % 16] = vexp;
         q_tag[q_tail % 16] = vtag;
         q_tail++;
         have_vec = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic feed(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [33:0] e, input string tag);
      va = a; vb = b; vs = sub; vexp = e; vtag = tag; have_vec = 1'b1;
      while (have_vec) step();
   endtask

   task automatic drain();
      have_vec = 1'b0;
      while (q_head != q_tail || out_valid) step();
   endtask

   function automatic int clip_exp(input int e);
      if (e < 1) return 1;
      if (e > 254) return 254;
      return e;
   endfunction

   task automatic gen_vec(input int pat);
      logic [31:0] r1, r2, r3;
      logic [22:0] fa, fb;
      int ea, eb;
      r1 = next_rand(); r2 = next_rand(); r3 = next_rand();
      fa = r1[22:0]; fb = r2[22:0];
      if (r3[3:0] == 4'd0) fa = fa & 23'h7FF000;   // trailing zeros make ties likely
      if (r3[7:4] == 4'd0) fb = fb & 23'h7FFF80;
      ea = 1 + int'(r3[15:8]) % 254;
      case (pat)
         0: eb = 1 + int'(r3[23:16]) % 254;
         1: eb = clip_exp(ea + int'(r3[19:16] % 9) - 4);
         2: eb = clip_exp(ea + int'(r3[21:16] % 61) - 30);
         3: begin ea = 250 + int'(r3[10:8] % 5); eb = 250 + int'(r3[18:16] % 5); end
         4: begin ea = 1 + int'(r3[10:8] % 6); eb = 1 + int'(r3[18:16] % 6); end
         default: eb = 0;
      endcase
      va = {r1[31], 8'(ea), fa};
      vb = {r2[31], 8'(eb), (r3[30] ? fb : 23'd0)};
      if (pat < 5) vb[22:0] = fb;
      vs = r3[31];
      vexp = model(va, vb, vs);
      vtag = (pat == 3) ? "R8" : (pat == 4) ? "R9" : (pat == 5) ? "R2" : (pat == 1) ? "R6" : "R4";
      have_vec = 1'b1;
      while (have_vec) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", out_valid == 1'b0, {33'd0, out_valid}, 34'd0, "out_valid in reset");
      check("R12", in_ready == 1'b1, {33'd0, in_ready}, 34'd1, "in_ready in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", out_valid == 1'b0 && in_ready == 1'b1, {32'd0, out_valid, in_ready}, 34'd1, "after reset");

      // directed values, computed by hand
      feed(32'h3F000000, 32'hBEE00000, 1'b0, {2'b00, 32'h3D800000}, "R1");
      feed(32'hC0A00000, 32'hBF400000, 1'b0, {2'b00, 32'hC0B80000}, "R1");
      feed(32'h40490FDB, 32'h00000000, 1'b0, {2'b00, 32'h40490FDB}, "R2");
      feed(32'h40490FDB, 32'h007FFFFF, 1'b0, {2'b00, 32'h40490FDB}, "R2");
      feed(32'h80000000, 32'h80000000, 1'b0, {2'b00, 32'h80000000}, "R2");
      feed(32'h00000000, 32'h80000000, 1'b0, {2'b00, 32'h00000000}, "R2");
      feed(32'h3FC00000, 32'hBFC00000, 1'b0, {2'b00, 32'h00000000}, "R3");
      feed(32'hC1200000, 32'hC1200000, 1'b1, {2'b00, 32'h00000000}, "R3");
      feed(32'h3F800000, 32'h33800000, 1'b0, {2'b00, 32'h3F800000}, "R4");
      feed(32'h3FC00000, 32'h3FC00000, 1'b0, {2'b00, 32'h40400000}, "R5");
      feed(32'h3F800001, 32'h3F800000, 1'b1, {2'b00, 32'h34000000}, "R6");
      feed(32'h3F7FFFFF, 32'h33000000, 1'b0, {2'b00, 32'h3F800000}, "R7");
      feed(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b10, 32'h7F800000}, "R8");
      feed(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {2'b10, 32'hFF800000}, "R8");
      feed(32'h00800000, 32'h80C00000, 1'b0, {2'b01, 32'h80000000}, "R9");
      feed(32'h40A00000, 32'h3F400000, 1'b1, {2'b00, 32'h40880000}, "R10");
      drain();

      // sweeps with full throughput, then with random backpressure
      for (int mode = 0; mode < 2; mode++) begin
         always_ready = (mode == 0) ? 1 : 0;
         for (int pat = 0; pat < 6; pat++) begin
            for (int n = 0; n < 350; n++) gen_vec(pat);
         end
         drain();
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL R11 watchdog: actual=hung expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule